// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins a host-side data line to a card-side data line. Both lines are open-drain with a passive pull-up. While nobody is talking, the block drives nothing and both lines rest high. The first side that pulls its line low becomes the leader for that transfer. After a programmable delay, the block copies the low level onto the other side, the follower. When the leader lets go, the block stops pulling the follower low. It then drives a short active pull-up pulse on the follower side, so that the rising edge is fast. The follower side is locked out for the whole transfer, so any edge it makes cannot steal the direction.

Each side gives the block a raw input level. For each side the block returns a pull-down enable and an active pull-up enable. One channel serves one line. The top module replicates the channel with a generate loop: by default there are three channels, for the main data line and two auxiliary lines. Everything runs on one fast system clock. The copy delay and the pull-up pulse length are parameters counted in system-clock cycles. With the default values on a 100 MHz clock, these are 130 ns from input to copy and a 100 ns pulse. This timing easily supports 1 MHz traffic. A global `inactive` input drives every output off and returns every channel to idle.

Each channel runs this state machine:

- **IDLE**: nothing is driven.
  - On a host falling edge, go to DELAY with the host as leader. The host wins if both sides fall in the same cycle.
  - On a card falling edge alone, go to DELAY with the card as leader.
- **DELAY**: count EDGE_DLY cycles, then go to COPY.
  - If the leader's line is seen high before the count ends, go to SETTLE instead.
- **COPY**: the follower pull-down is on.
  - When the leader's line is seen high, go to BOOST.
- **BOOST**: the follower active pull-up is on for PU_LEN cycles, then go to SETTLE.
- **SETTLE**: nothing is driven.
  - Once both synchronized levels are high, go to IDLE.
- **Any state**: while `inactive` is high, go to IDLE and reset the leader to host.

Top module: `od_link_bank`

## Requirements
- R1: After reset, every pull-down and pull-up output is 0. The outputs stay 0 while both lines are idle high.
- R2: A host line that goes low turns on `card_pd` of that channel exactly EDGE_DLY+3 clock edges after the low level is applied. It is still 0 one edge earlier. `host_pd` stays 0.
- R3: A card line that goes low turns on `host_pd` of that channel exactly EDGE_DLY+3 edges later. `card_pd` stays 0.
- R4: If both lines of a channel fall in the same cycle, the host leads. `card_pd` turns on at EDGE_DLY+3, and `host_pd` stays 0.
- R5: While a leader is assigned, falling edges on the follower side change nothing. Copy timing and direction stay those of the leader, and the pull-up pulse lands on the follower side.
- R6: After the leader line returns high, the follower pull-down stays on for 2 more edges and turns off at the 3rd edge. At that same edge, the follower pull-up turns on for exactly PU_LEN cycles and then turns off.
- R7: If the leader releases its line before the copy delay ends, neither pull-down of that channel is ever turned on.
- R8: While `inactive` is high, all outputs are 0, with no clock edge needed. After `inactive` falls, a line that is still held low does not restart a transfer. Only a fresh falling edge does.
- R9: A transfer on one channel leaves the outputs of the other channels at 0.
- R10: The leader side is never driven, and a channel never pulls down both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inactive | input | 1 | Forces all channels idle and all drive off |
| host_in | input | NCH | Raw host-side line levels, one bit per channel |
| card_in | input | NCH | Raw card-side line levels, one bit per channel |
| host_pd | output | NCH | Host-side pull-down enables |
| host_pu | output | NCH | Host-side active pull-up enables |
| card_pd | output | NCH | Card-side pull-down enables |
| card_pu | output | NCH | Card-side active pull-up enables |

## Verification
A falling input reaches the state register through two synchronizer flops and one edge register. The follower pull-down is therefore due EDGE_DLY+3 edges after the stimulus, and the release response is due 3 edges after the leader goes high. The pull-up then lasts PU_LEN edges. The `inactive` gating acts combinationally within the same cycle. The bench drives every input and samples every output on falling clock edges. It checks each timed output one edge before it is due and again on the edge it is due, so an off-by-one in either direction is reported.

// File: rtl/od_link_pkg.sv
package od_link_pkg;

    typedef enum logic [2:0] {
        LK_IDLE   = 3'd0,
        LK_DELAY  = 3'd1,
        LK_COPY   = 3'd2,
        LK_BOOST  = 3'd3,
        LK_SETTLE = 3'd4
    } lk_state_e;

    typedef enum logic {
        LEAD_HOST = 1'b0,
        LEAD_CARD = 1'b1
    } lead_e;

endpackage

// File: rtl/od_sync_edge.sv
// Multi-flop synchronizer followed by a registered copy for fall detection.
module od_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '1;
            prv <= 1'b1;
        end else begin
            sh  <= {sh[STAGES-2:0], d};
            prv <= sh[STAGES-1];
        end
    end

    assign lvl  = sh[STAGES-1];
    assign fall = prv & ~sh[STAGES-1];
endmodule

// File: rtl/od_link_fsm.sv
module od_link_fsm
    import od_link_pkg::*;
#(
    parameter int EDGE_DLY = 10,
    parameter int PU_LEN   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inactive,
    input  logic host_lvl,
    input  logic card_lvl,
    input  logic host_fall,
    input  logic card_fall,
    output logic host_pd,
    output logic host_pu,
    output logic card_pd,
    output logic card_pu
);
    localparam int CNT_MAX = (EDGE_DLY > PU_LEN) ? EDGE_DLY : PU_LEN;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(EDGE_DLY - 1);
    localparam logic [CW-1:0] PU_LAST  = CW'(PU_LEN - 1);

    lk_state_e      st, st_nxt;
    lead_e          lead, lead_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;
    logic           lead_lvl;

    assign lead_lvl = (lead == LEAD_HOST) ? host_lvl : card_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= LK_IDLE;
            lead <= LEAD_HOST;
            cnt  <= '0;
        end else begin
            st   <= st_nxt;
            lead <= lead_nxt;
            cnt  <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt   = st;
        lead_nxt = lead;
        cnt_nxt  = cnt;
        unique case (st)
            LK_IDLE: begin
                if (host_fall) begin
                    st_nxt   = LK_DELAY;
                    lead_nxt = LEAD_HOST;
                    cnt_nxt  = '0;
                end else if (card_fall) begin
                    st_nxt   = LK_DELAY;
                    lead_nxt = LEAD_CARD;
                    cnt_nxt  = '0;
                end
            end
            LK_DELAY: begin
                if (lead_lvl)              st_nxt = LK_SETTLE;
                else if (cnt == DLY_LAST)  st_nxt = LK_COPY;
                else                       cnt_nxt = cnt + 1'b1;
            end
            LK_COPY: begin
                if (lead_lvl) begin
                    st_nxt  = LK_BOOST;
                    cnt_nxt = '0;
                end
            end
            LK_BOOST: begin
                if (cnt == PU_LAST) st_nxt  = LK_SETTLE;
                else                cnt_nxt = cnt + 1'b1;
            end
            LK_SETTLE: begin
                if (host_lvl && card_lvl) st_nxt = LK_IDLE;
            end
            default: st_nxt = LK_IDLE;
        endcase
        if (inactive) begin
            st_nxt   = LK_IDLE;
            lead_nxt = LEAD_HOST;
            cnt_nxt  = '0;
        end
    end

    // outputs: follower side only, gated off while inactive
    always_comb begin
        host_pd = 1'b0;
        host_pu = 1'b0;
        card_pd = 1'b0;
        card_pu = 1'b0;
        if (!inactive) begin
            case (st)
                LK_COPY: begin
                    if (lead == LEAD_HOST) card_pd = 1'b1;
                    else                   host_pd = 1'b1;
                end
                LK_BOOST: begin
                    if (lead == LEAD_HOST) card_pu = 1'b1;
                    else                   host_pu = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/od_link_chan.sv
module od_link_chan #(
    parameter int EDGE_DLY    = 10,
    parameter int PU_LEN      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inactive,
    input  logic host_raw,
    input  logic card_raw,
    output logic host_pd,
    output logic host_pu,
    output logic card_pd,
    output logic card_pu
);
    logic h_lvl, h_fall, c_lvl, c_fall;

    od_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst_n(rst_n), .d(host_raw), .lvl(h_lvl), .fall(h_fall)
    );
    od_sync_edge #(.STAGES(SYNC_STAGES)) u_csync (
        .clk(clk), .rst_n(rst_n), .d(card_raw), .lvl(c_lvl), .fall(c_fall)
    );

    od_link_fsm #(.EDGE_DLY(EDGE_DLY), .PU_LEN(PU_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .inactive(inactive),
        .host_lvl(h_lvl), .card_lvl(c_lvl),
        .host_fall(h_fall), .card_fall(c_fall),
        .host_pd(host_pd), .host_pu(host_pu),
        .card_pd(card_pd), .card_pu(card_pu)
    );
endmodule

// File: rtl/od_link_bank.sv
module od_link_bank #(
    parameter int NCH         = 3,
    parameter int EDGE_DLY    = 10,
    parameter int PU_LEN      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inactive,
    input  logic [NCH-1:0] host_in,
    input  logic [NCH-1:0] card_in,
    output logic [NCH-1:0] host_pd,
    output logic [NCH-1:0] host_pu,
    output logic [NCH-1:0] card_pd,
    output logic [NCH-1:0] card_pu
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        od_link_chan #(
            .EDGE_DLY(EDGE_DLY), .PU_LEN(PU_LEN), .SYNC_STAGES(SYNC_STAGES)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .inactive(inactive),
            .host_raw(host_in[g]), .card_raw(card_in[g]),
            .host_pd(host_pd[g]), .host_pu(host_pu[g]),
            .card_pd(card_pd[g]), .card_pu(card_pu[g])
        );
    end
endmodule

// File: rtl/od_link_chk.sv
module od_link_chk #(
    parameter int NCH    = 3,
    parameter int PU_LEN = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           inactive,
    input logic [NCH-1:0] host_in,
    input logic [NCH-1:0] card_in,
    input logic [NCH-1:0] host_pd,
    input logic [NCH-1:0] host_pu,
    input logic [NCH-1:0] card_pd,
    input logic [NCH-1:0] card_pu
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        int c_run, h_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_run <= 0;
                h_run <= 0;
            end else begin
                c_run <= card_pu[g] ? c_run + 1 : 0;
                h_run <= host_pu[g] ? h_run + 1 : 0;
            end
        end

        assert_one_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_pd[g] && card_pd[g]));
        assert_card_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(card_pd[g]) |-> !$past(host_in[g], 2));
        assert_host_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(host_pd[g]) |-> !$past(card_in[g], 2));
        assert_card_pu_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(card_pu[g]) |-> $past(card_pd[g]));
        assert_host_pu_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(host_pu[g]) |-> $past(host_pd[g]));
        assert_card_pu_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
            card_pu[g] |-> (c_run < PU_LEN));
        assert_host_pu_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
            host_pu[g] |-> (h_run < PU_LEN));
        assert_quiet_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(inactive) |-> (!host_pd[g] && !card_pd[g] && !host_pu[g] && !card_pu[g]));
    end
endmodule

bind od_link_bank od_link_chk #(.NCH(NCH), .PU_LEN(PU_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .inactive(inactive),
    .host_in(host_in), .card_in(card_in),
    .host_pd(host_pd), .host_pu(host_pu),
    .card_pd(card_pd), .card_pu(card_pu)
);

// File: tb/test_od_link_bank.sv
module test_od_link_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int D   = 10;
    localparam int P   = 10;
    localparam int NV  = 6;

    typedef struct packed {
        int ch;
        int card_lead;
        int low_len;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{ch: 0, card_lead: 0, low_len: 20},
        '{ch: 1, card_lead: 1, low_len: 30},
        '{ch: 2, card_lead: 0, low_len: 5},
        '{ch: 0, card_lead: 1, low_len: 1},
        '{ch: 2, card_lead: 1, low_len: 100},
        '{ch: 1, card_lead: 0, low_len: 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inactive = 1'b0;
    logic [NCH-1:0] host_drv = '1, card_drv = '1;
    logic [NCH-1:0] host_in, card_in, host_pd, host_pu, card_pd, card_pu;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign host_in = host_drv & ~host_pd;
    assign card_in = card_drv & ~card_pd;

    od_link_bank #(.NCH(NCH), .EDGE_DLY(D), .PU_LEN(P), .SYNC_STAGES(2)) i_od_link_bank (
        .clk(clk), .rst_n(rst_n), .inactive(inactive),
        .host_in(host_in), .card_in(card_in),
        .host_pd(host_pd), .host_pu(host_pu),
        .card_pd(card_pd), .card_pu(card_pu)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // one full transfer: leader low, copy, release, pull-up pulse
    task automatic xfer(int ch, int cl, int low_len);
        string rq;
        int others;
        rq = cl ? "R3" : "R2";
        if (cl) card_drv[ch] = 1'b0; else host_drv[ch] = 1'b0;
        step(D + 2);
        chk(rq, "follower pd one edge early", cl ? host_pd[ch] : card_pd[ch], 0);
        step(1);
        chk(rq, "follower pd on time", cl ? host_pd[ch] : card_pd[ch], 1);
        chk("R10", "leader pd", cl ? card_pd[ch] : host_pd[ch], 0);
        others = 0;
        for (int k = 0; k < NCH; k++)
            if (k != ch) others += host_pd[k] + card_pd[k] + host_pu[k] + card_pu[k];
        chk("R9", "other channel drive", others, 0);
        step(low_len);
        if (cl) card_drv[ch] = 1'b1; else host_drv[ch] = 1'b1;
        step(2);
        chk("R6", "pd held 2 edges after release", cl ? host_pd[ch] : card_pd[ch], 1);
        step(1);
        chk("R6", "pd off at 3rd edge", cl ? host_pd[ch] : card_pd[ch], 0);
        chk("R6", "pu on at 3rd edge", cl ? host_pu[ch] : card_pu[ch], 1);
        step(P - 1);
        chk("R6", "pu still on at end", cl ? host_pu[ch] : card_pu[ch], 1);
        step(1);
        chk("R6", "pu off after PU_LEN", cl ? host_pu[ch] : card_pu[ch], 0);
        chk("R10", "leader pu", cl ? card_pu[ch] : host_pu[ch], 0);
        step(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seen;
        step(3);
        chk("R1", "outputs in reset", int'(host_pd | host_pu | card_pd | card_pu), 0);
        rst_n = 1'b1;
        step(6);
        chk("R1", "outputs idle after reset", int'(host_pd | host_pu | card_pd | card_pu), 0);

        // stimulus/expectation table walk
        for (int v = 0; v < NV; v++)
            xfer(VECS[v].ch, VECS[v].card_lead, VECS[v].low_len);

        // R5: follower edges during DELAY are ignored
        host_drv[0] = 1'b0;
        step(3);
        card_drv[0] = 1'b0;
        step(3);
        card_drv[0] = 1'b1;
        step(D - 4);
        chk("R5", "card pd early", card_pd[0], 0);
        step(1);
        chk("R5", "card pd on time despite card edge", card_pd[0], 1);
        chk("R5", "host pd stays off", host_pd[0], 0);
        host_drv[0] = 1'b1;
        step(3);
        chk("R5", "pu on card side", card_pu[0], 1);
        chk("R5", "no pu on host side", host_pu[0], 0);
        step(P + 5);

        // R4: simultaneous falls, host wins
        host_drv[2] = 1'b0;
        card_drv[2] = 1'b0;
        step(D + 3);
        chk("R4", "card pd after tie", card_pd[2], 1);
        chk("R4", "host pd after tie", host_pd[2], 0);
        card_drv[2] = 1'b1;
        step(5);
        chk("R4", "card pd held", card_pd[2], 1);
        host_drv[2] = 1'b1;
        step(3);
        chk("R4", "card pu after tie release", card_pu[2], 1);
        chk("R4", "host pu after tie release", host_pu[2], 0);
        step(P + 5);

        // R7: short low never copied
        host_drv[1] = 1'b0;
        step(2);
        host_drv[1] = 1'b1;
        seen = 0;
        for (int k = 0; k < D + 8; k++) begin
            step(1);
            seen += card_pd[1] + host_pd[1];
        end
        chk("R7", "pd cycles after short low", seen, 0);

        // R8: inactive kills drive, held low does not restart
        host_drv[0] = 1'b0;
        step(D + 3);
        chk("R8", "card pd before inactive", card_pd[0], 1);
        inactive = 1'b1;
        #1;
        chk("R8", "card pd during inactive", card_pd[0], 0);
        step(2);
        inactive = 1'b0;
        seen = 0;
        for (int k = 0; k < D + 6; k++) begin
            step(1);
            seen += card_pd[0] + host_pd[0] + card_pu[0] + host_pu[0];
        end
        chk("R8", "drive cycles with held-low line", seen, 0);
        host_drv[0] = 1'b1;
        step(5);
        host_drv[0] = 1'b0;
        step(D + 3);
        chk("R8", "fresh edge restarts copy", card_pd[0], 1);
        host_drv[0] = 1'b1;
        step(P + 8);
        chk("R1", "all idle at end", int'(host_pd | host_pu | card_pd | card_pu), 0);

        finish_run();
    end
endmodule